// File: doc/BRIEF.md
# I/Q Serial Frame Formatter

This block turns one pair of 16-bit I and Q samples into a serial frame on a single data line. It is paced by a bit-clock enable that the surrounding logic produces. A one-cycle `sample_valid` strobe hands over a sample pair together with the current gain DAC code. The block latches a complete frame image and shifts it out MSB first, one bit for each enable. The data line rests high between frames. A frame-sync pulse marks the first bit of every frame.

Gain-control status can be appended to each frame. The status covers the DAC code and three 2-bit saturating counts of overload, reset and large-signal events. In word mode every frame carries both the gain byte and the status byte. In alternating mode each frame carries one of the two bytes, and the LSB of that byte tells a receiver which one it is. An event counter is cleared by the frame that reports it. A gain-only frame does not clear the counters.

The controller has three named states. `S_IDLE` waits for a strobe. On acceptance it moves to `S_ARMED` (IDLE→ARMED, frame latched). `S_ARMED` waits for the next bit enable. On that enable it emits the first bit with frame sync and moves to `S_SHIFT` (ARMED→SHIFT). `S_SHIFT` emits one bit per enable. After the last bit it drives one idle-high bit and returns (SHIFT→IDLE). Any other situation holds the current state.

Top module: `iqf_serializer`

## Requirements
- R1: A frame sends I bits 15..0 and then Q bits 15..0. With `cfg_status_en`=0 the frame is exactly 32 bits long.
- R2: With `cfg_status_en`=1 and `cfg_alt_mode`=0 the frame is 48 bits long. The 32 sample bits are followed first by the 8-bit gain DAC code (MSB first) and then by the status byte.
- R3: Status byte encoding, from bit 7 down to bit 0: [7:6] overload count, [5:4] reset count, [3:2] large-signal count, [1] = 0, [0] = 1.
- R4: Each event count is the number of strobes seen on its event input since the last report, held at 3 once three or more have arrived.
- R5: The counts are cleared by the acceptance of a frame that carries the status byte. An event strobe in the same clock as that acceptance counts toward the next report. A frame that carries no status byte leaves the counts untouched.
- R6: With `cfg_status_en`=1 and `cfg_alt_mode`=1 each frame is 40 bits long. Successive such frames alternate between a gain byte, which holds DAC bits 7..1 with LSB 0, and the status byte. The first such frame after reset carries the gain byte.
- R7: After reset and between frames `sdata` is 1, `fsync` is 0 and `overrun` is 0. At least one idle-high bit follows every frame.
- R8: `fsync` is 1 for exactly the bit period of the first I bit and 0 for every other bit.
- R9: A `sample_valid` strobe that arrives while a frame is pending or shifting is dropped, and the frame in flight is not altered. Such a strobe sets `overrun`, which stays 1 until reset.
- R10: `sdata` and `fsync` change only on clocks where `bit_en` is 1. The first bit of an accepted frame appears on the first `bit_en` after the acceptance clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-clock enable marking each output bit period |
| sample_valid | input | 1 | Strobe offering a new I/Q pair |
| i_sample | input | SAMPLE_W | In-phase sample |
| q_sample | input | SAMPLE_W | Quadrature sample |
| gain_dac | input | GAIN_W | Current gain DAC code |
| ev_overload | input | 1 | Overload event strobe |
| ev_reset | input | 1 | Reset event strobe |
| ev_large | input | 1 | Large-signal event strobe |
| cfg_status_en | input | 1 | Append gain status to frames |
| cfg_alt_mode | input | 1 | Alternate gain and status bytes across frames |
| sdata | output | 1 | Serial data line, MSB first, idles high |
| fsync | output | 1 | Frame sync, high during the first bit |
| overrun | output | 1 | Sticky flag for a dropped sample strobe |

## Verification
The bench builds the block with its defaults: SAMPLE_W=16, GAIN_W=8 and CNT_W=2. With these values the status byte is exactly as wide as the gain byte, so both alternating frame kinds are 40 bits and the word frame is 48. A 2-bit count reaches saturation after only three event strobes, so the table can drive counts past the limit in a few cycles. Because `bit_en` fires on every third clock, a wrong hold between enables or a frame that starts too early shows up at the ports.

// File: rtl/iqf_pkg.sv
package iqf_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARMED,
        S_SHIFT
    } ser_state_t;

endpackage

// File: rtl/iqf_event_cnt.sv
module iqf_event_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            // an event in the reporting cycle opens the next window
            cnt <= inc ? CNT_W'(1) : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    assert_clear_on_report_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt == '0));

endmodule

// File: rtl/iqf_frame_ctrl.sv
module iqf_frame_ctrl
    import iqf_pkg::*;
#(
    parameter int FRAME_W = 48,
    parameter int LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic               sample_valid,
    input  logic [FRAME_W-1:0] frame_img,
    input  logic [LEN_W-1:0]   frame_len,
    output logic               accept,
    output logic               sdata,
    output logic               fsync,
    output logic               overrun
);

    ser_state_t         state, nxt;
    logic [FRAME_W-1:0] sr_q;
    logic [LEN_W-1:0]   rem_q;

    assign accept = sample_valid && (state == S_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (sample_valid)               nxt = S_ARMED;
            S_ARMED: if (bit_en)                     nxt = S_SHIFT;
            S_SHIFT: if (bit_en && rem_q == '0)      nxt = S_IDLE;
            default:                                 nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= '1;
            rem_q   <= '0;
            sdata   <= 1'b1;
            fsync   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (sample_valid && (state != S_IDLE)) overrun <= 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (sample_valid) begin
                        sr_q  <= frame_img;
                        rem_q <= frame_len;
                    end
                end
                S_ARMED: begin
                    if (bit_en) begin
                        sdata <= sr_q[FRAME_W-1];
                        fsync <= 1'b1;
                        sr_q  <= {sr_q[FRAME_W-2:0], 1'b1};
                        rem_q <= rem_q - 1'b1;
                    end
                end
                S_SHIFT: begin
                    if (bit_en) begin
                        fsync <= 1'b0;
                        if (rem_q == '0) begin
                            sdata <= 1'b1;
                        end else begin
                            sdata <= sr_q[FRAME_W-1];
                            sr_q  <= {sr_q[FRAME_W-2:0], 1'b1};
                            rem_q <= rem_q - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_fsync_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync) |=> !fsync);

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> sdata);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    assert_hold_between_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdata) && $stable(fsync)));

endmodule

// File: rtl/iqf_serializer.sv
module iqf_serializer #(
    parameter int SAMPLE_W = 16,
    parameter int GAIN_W   = 8,
    parameter int CNT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] i_sample,
    input  logic [SAMPLE_W-1:0] q_sample,
    input  logic [GAIN_W-1:0]   gain_dac,
    input  logic                ev_overload,
    input  logic                ev_reset,
    input  logic                ev_large,
    input  logic                cfg_status_en,
    input  logic                cfg_alt_mode,
    output logic                sdata,
    output logic                fsync,
    output logic                overrun
);

    localparam int N_EV    = 3;
    localparam int STAT_W  = N_EV * CNT_W + 2;
    localparam int L_BASE  = 2 * SAMPLE_W;
    localparam int FRAME_W = L_BASE + GAIN_W + STAT_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic [N_EV-1:0]  ev_vec;
    logic [CNT_W-1:0] cnt_q [N_EV];
    logic [STAT_W-1:0] stat_byte;
    logic              accept;
    logic              report;
    logic              alt_stat_next;
    logic [FRAME_W-1:0] img;
    logic [LEN_W-1:0]   len;

    // index 2: overload, 1: reset, 0: large-signal
    assign ev_vec = {ev_overload, ev_reset, ev_large};

    generate
        for (genvar g = 0; g < N_EV; g++) begin : g_evc
            iqf_event_cnt #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (ev_vec[g]),
                .clr   (report),
                .cnt   (cnt_q[g])
            );
        end
    endgenerate

    assign stat_byte = {cnt_q[2], cnt_q[1], cnt_q[0], 1'b0, 1'b1};
    assign report    = accept && cfg_status_en && (!cfg_alt_mode || alt_stat_next);

    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_stat_next <= 1'b0;
        else if (accept && cfg_status_en && cfg_alt_mode)
            alt_stat_next <= !alt_stat_next;
    end

    always_comb begin
        if (!cfg_status_en) begin
            img = {i_sample, q_sample, {(FRAME_W-L_BASE){1'b1}}};
            len = LEN_W'(L_BASE);
        end else if (!cfg_alt_mode) begin
            img = {i_sample, q_sample, gain_dac, stat_byte};
            len = LEN_W'(FRAME_W);
        end else if (alt_stat_next) begin
            img = {i_sample, q_sample, stat_byte, {GAIN_W{1'b1}}};
            len = LEN_W'(L_BASE + STAT_W);
        end else begin
            img = {i_sample, q_sample, gain_dac[GAIN_W-1:1], 1'b0, {STAT_W{1'b1}}};
            len = LEN_W'(L_BASE + GAIN_W);
        end
    end

    iqf_frame_ctrl #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .sample_valid (sample_valid),
        .frame_img    (img),
        .frame_len    (len),
        .accept       (accept),
        .sdata        (sdata),
        .fsync        (fsync),
        .overrun      (overrun)
    );

    assert_alt_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_status_en && cfg_alt_mode) |=> (alt_stat_next != $past(alt_stat_next)));

endmodule

// File: tb/tb_iqf_serializer.sv
module tb_iqf_serializer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        en_seen = 1'b0;
    logic [1:0]  div = '0;
    logic        sample_valid = 1'b0;
    logic [15:0] i_sample = '0;
    logic [15:0] q_sample = '0;
    logic [7:0]  gain_dac = '0;
    logic        ev_overload = 1'b0;
    logic        ev_reset = 1'b0;
    logic        ev_large = 1'b0;
    logic        cfg_status_en = 1'b0;
    logic        cfg_alt_mode = 1'b0;
    logic        sdata, fsync, overrun;

    int checks = 0;
    int errors = 0;

    iqf_serializer dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sample_valid(sample_valid),
        .i_sample(i_sample), .q_sample(q_sample), .gain_dac(gain_dac),
        .ev_overload(ev_overload), .ev_reset(ev_reset), .ev_large(ev_large),
        .cfg_status_en(cfg_status_en), .cfg_alt_mode(cfg_alt_mode),
        .sdata(sdata), .fsync(fsync), .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // bit enable on every third clock; en_seen is what the last edge saw
    always @(posedge clk) begin
        div     <= (div == 2'd2) ? 2'd0 : div + 2'd1;
        bit_en  <= (div == 2'd1);
        en_seen <= bit_en;
    end

    typedef struct packed {
        logic        se;
        logic        alt;
        logic [15:0] i;
        logic [15:0] q;
        logic [7:0]  g;
        logic [2:0]  nov;
        logic [2:0]  nrs;
        logic [2:0]  nlg;
        logic [5:0]  len;
        logic [15:0] tail;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{1'b0, 1'b0, 16'hA5C3, 16'h1234, 8'h5A, 3'd1, 3'd0, 3'd0, 6'd32, 16'h0000},
        '{1'b1, 1'b0, 16'hFFFF, 16'h0000, 8'hC3, 3'd0, 3'd2, 3'd5, 6'd48, 16'hC36D},
        '{1'b1, 1'b1, 16'h8001, 16'h7FFE, 8'hB7, 3'd4, 3'd1, 3'd0, 6'd40, 16'hB600},
        '{1'b1, 1'b1, 16'h0F0F, 16'hF0F0, 8'h00, 3'd0, 3'd0, 3'd2, 6'd40, 16'hD900},
        '{1'b1, 1'b1, 16'h1357, 16'h9BDF, 8'hFF, 3'd0, 3'd0, 3'd0, 6'd40, 16'hFE00},
        '{1'b1, 1'b1, 16'h2468, 16'hACE0, 8'h3C, 3'd0, 3'd0, 3'd0, 6'd40, 16'h0100},
        '{1'b1, 1'b0, 16'h0001, 16'h8000, 8'h01, 3'd3, 3'd0, 3'd0, 6'd48, 16'h01C1}
    };

    task automatic chk(input bit ok, input string what, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic pulse_events(input int nov, input int nrs, input int nlg);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ev_overload = (k < nov);
            ev_reset    = (k < nrs);
            ev_large    = (k < nlg);
        end
        @(negedge clk);
        ev_overload = 1'b0; ev_reset = 1'b0; ev_large = 1'b0;
    endtask

    task automatic offer(input logic se, input logic alt, input logic [15:0] i,
                         input logic [15:0] q, input logic [7:0] g, input logic ov_same);
        @(negedge clk);
        cfg_status_en = se; cfg_alt_mode = alt;
        i_sample = i; q_sample = q; gain_dac = g;
        sample_valid = 1'b1; ev_overload = ov_same;
        @(negedge clk);
        sample_valid = 1'b0; ev_overload = 1'b0;
    endtask

    task automatic collect(input int len, input int inject, output logic [47:0] got,
                           output bit ok_fs, output bit ok_first, output bit ok_idle);
        int n = 0;
        int inj = inject;
        got = '0; ok_fs = 1'b1; ok_first = 1'b1; ok_idle = 1'b0;
        forever begin
            @(negedge clk);
            sample_valid = 1'b0;
            if (en_seen) begin
                if (n == 0) begin
                    if (fsync) begin
                        got = {got[46:0], sdata};
                        n = 1;
                    end else begin
                        ok_first = 1'b0;
                    end
                end else if (n < len) begin
                    if (fsync) ok_fs = 1'b0;
                    got = {got[46:0], sdata};
                    n++;
                end else begin
                    ok_idle = (sdata == 1'b1) && (fsync == 1'b0);
                    break;
                end
            end
            if (inj > 0 && n == inj) begin
                sample_valid = 1'b1;
                i_sample = 16'h2222;
                inj = 0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] got, exp;
        bit ok_fs, ok_first, ok_idle;
        int seen;

        repeat (4) @(negedge clk);
        // R7: reset values
        chk(sdata == 1'b1 && fsync == 1'b0 && overrun == 1'b0, "R7 reset state",
            {45'd0, sdata, fsync, overrun}, 48'b100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdata == 1'b1 && fsync == 1'b0, "R7 idle after reset", {46'd0, sdata, fsync}, 48'b10);

        // table walk: R1 R2 R3 R4 R5 R6 frame contents, R8 sync, R10 start, R7 idle bit
        for (int v = 0; v < 7; v++) begin
            pulse_events(int'(VECS[v].nov), int'(VECS[v].nrs), int'(VECS[v].nlg));
            offer(VECS[v].se, VECS[v].alt, VECS[v].i, VECS[v].q, VECS[v].g, 1'b0);
            collect(int'(VECS[v].len), 0, got, ok_fs, ok_first, ok_idle);
            exp = {VECS[v].i, VECS[v].q, VECS[v].tail} >> (48 - int'(VECS[v].len));
            chk(got == exp, $sformatf("R1 R2 R3 R4 R5 R6 frame content vector %0d", v), got, exp);
            chk(ok_fs && ok_first, $sformatf("R8 R10 frame sync placement vector %0d", v),
                {46'd0, ok_fs, ok_first}, 48'b11);
            chk(ok_idle, $sformatf("R7 idle-high bit after vector %0d", v), {47'd0, ok_idle}, 48'd1);
        end
        chk(overrun == 1'b0, "R9 no overrun for spaced strobes", {47'd0, overrun}, 48'd0);

        // R5: event in the same clock as the reporting acceptance goes to the next report
        offer(1'b1, 1'b0, 16'hCAFE, 16'hBEEF, 8'h81, 1'b1);
        collect(48, 0, got, ok_fs, ok_first, ok_idle);
        exp = {16'hCAFE, 16'hBEEF, 8'h81, 8'h01};
        chk(got == exp, "R5 same-cycle event not in current report", got, exp);
        offer(1'b1, 1'b0, 16'h0F0F, 16'h00FF, 8'h7E, 1'b0);
        collect(48, 0, got, ok_fs, ok_first, ok_idle);
        exp = {16'h0F0F, 16'h00FF, 8'h7E, 8'h41};
        chk(got == exp, "R5 same-cycle event in next report", got, exp);

        // R9: strobe during shifting is dropped, frame intact, flag sticky
        offer(1'b0, 1'b0, 16'h1111, 16'h3333, 8'h00, 1'b0);
        collect(32, 5, got, ok_fs, ok_first, ok_idle);
        exp = {16'd0, 16'h1111, 16'h3333};
        chk(got == exp, "R9 frame in flight unaltered", got, exp);
        chk(ok_idle, "R9 R7 idle after overrun frame", {47'd0, ok_idle}, 48'd1);
        seen = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (fsync) seen++;
        end
        chk(seen == 0, "R9 dropped strobe starts no frame", 48'(seen), 48'd0);
        chk(overrun == 1'b1, "R9 overrun flag set and held", {47'd0, overrun}, 48'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule